// File: doc/BRIEF.md
# UART Software Flow Controller (XON/XOFF)

This block sits beside one UART channel and handles in-band flow control in hardware. It watches the fill level of the receive FIFO. When the level climbs to a programmable halt threshold, it queues a stop character. It sends that character to the serializer ahead of any waiting data byte. After the host drains the FIFO down to a programmable resume threshold, it queues a go character.

On the receive side it inspects every incoming byte. A stop code pauses the local data transmitter and a go code releases it. Both codes are consumed and never reach the FIFO. All other bytes pass straight through, including bytes that arrive after the FIFO has crossed the halt threshold.

A separate service interrupt rises when the FIFO level reaches its own trigger threshold. The trigger normally sits below the halt level, so the host is alerted before the far end is stopped. The codes and thresholds live in a small write-only register file. The two character codes survive reset.

Top module: `sfc_flow_ctrl`

## Requirements
- R1: While no stop character is queued or outstanding, a FIFO level greater than or equal to the halt threshold queues the stop character. From the next cycle on, `ser_req` is high with `ser_byte` equal to the stop code.
- R2: The go character is queued only after the stop character has been accepted by the serializer and the FIFO level is less than or equal to the resume threshold. Levels that stay high while a stop character is outstanding produce no second stop character.
- R3: A queued control character takes precedence over data. `ser_byte` carries the control code, `tx_pop` stays low, and the character is offered even while the local transmitter is paused.
- R4: A received byte equal to the stop code pauses data transmission from the next cycle: `ser_req` stays low for data while no control character is queued. A received byte equal to the go code lifts the pause from the next cycle.
- R5: A received byte equal to either control code is not forwarded (`rx_fifo_wr` low). Any other byte is forwarded in the same cycle with `rx_fifo_data` equal to it, whatever the FIFO level.
- R6: `irq` is a registered flag. It is high in the cycle after a cycle in which the FIFO level was greater than or equal to the trigger threshold, and low otherwise.
- R7: A write with `cfg_wr` high loads `cfg_wdata` into a register selected by `cfg_addr`, effective from the next cycle. The addresses are: 0 = stop code, 1 = go code, 2 = halt threshold, 3 = resume threshold, 4 = trigger threshold. Thresholds take the low bits of `cfg_wdata`.
- R8: Synchronous reset sets the thresholds to halt 60, resume 32 and trigger 52. It clears the pause, clears any queued or outstanding control character and drops `irq`. Reset leaves the two character codes unchanged.
- R9: A byte is handed over in a cycle where `ser_req` and `ser_grant` are both high. `tx_pop` is high only in such a cycle and only for a data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| rx_level | input | 7 | Current receive FIFO fill level |
| rx_valid | input | 1 | Received byte strobe from the deserializer |
| rx_data | input | 8 | Received byte |
| rx_fifo_wr | output | 1 | Write strobe into the receive FIFO |
| rx_fifo_data | output | 8 | Byte written into the receive FIFO |
| tx_valid | input | 1 | Transmit FIFO has a data byte ready |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_pop | output | 1 | Removes the head byte from the transmit FIFO |
| ser_req | output | 1 | Byte offered to the serializer |
| ser_byte | output | 8 | Byte offered to the serializer |
| ser_grant | input | 1 | Serializer accepts the offered byte |
| irq | output | 1 | Receive-service interrupt |

## Verification
Some rules are checked on every cycle by the assertions. Data is popped only on an accepted handshake. Control codes never reach the FIFO. A paused transmitter offers nothing unless a control character is queued. The interrupt always matches the previous cycle's level against the trigger. A go character is queued only from the outstanding-stop state with the level at or below the resume threshold. Reset returns to the open, unpaused state.

Other behaviour only the bench scenarios can show. These are the full fill-and-drain sequence with its hysteresis, a late byte accepted above the halt level, codes kept across reset, and thresholds changed at run time. They also include the exact byte chosen when a control character and data compete.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_AW = 3;

    typedef logic [BYTE_W-1:0] byte_t;

    // register select values
    localparam logic [CFG_AW-1:0] ADDR_STOP   = 3'd0;
    localparam logic [CFG_AW-1:0] ADDR_GO     = 3'd1;
    localparam logic [CFG_AW-1:0] ADDR_HALT   = 3'd2;
    localparam logic [CFG_AW-1:0] ADDR_RESUME = 3'd3;
    localparam logic [CFG_AW-1:0] ADDR_TRIG   = 3'd4;

    typedef enum logic [1:0] {
        FL_OPEN      = 2'd0,   // nothing outstanding
        FL_STOP_PEND = 2'd1,   // stop char waiting for serializer
        FL_STOPPED   = 2'd2,   // stop char sent, far end halted
        FL_GO_PEND   = 2'd3    // go char waiting for serializer
    } flow_st_t;

    typedef struct packed {
        byte_t stop_code;
        byte_t go_code;
    } ctl_codes_t;

    function automatic logic is_ctl_code(byte_t b, ctl_codes_t c);
        return (b == c.stop_code) || (b == c.go_code);
    endfunction

    function automatic logic ctl_pending(flow_st_t s);
        return (s == FL_STOP_PEND) || (s == FL_GO_PEND);
    endfunction

endpackage

// File: rtl/sfc_cfg_regs.sv
module sfc_cfg_regs
    import sfc_pkg::*;
#(
    parameter int LVL_W       = 7,
    parameter int HALT_INIT   = 60,
    parameter int RESUME_INIT = 32,
    parameter int TRIG_INIT   = 52
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  byte_t             cfg_wdata,
    output ctl_codes_t        codes,
    output logic [LVL_W-1:0]  halt_thr,
    output logic [LVL_W-1:0]  resume_thr,
    output logic [LVL_W-1:0]  trig_thr
);

    localparam logic [LVL_W-1:0] HALT_RST   = LVL_W'(HALT_INIT);
    localparam logic [LVL_W-1:0] RESUME_RST = LVL_W'(RESUME_INIT);
    localparam logic [LVL_W-1:0] TRIG_RST   = LVL_W'(TRIG_INIT);

    logic [LVL_W-1:0] wr_lvl;
    assign wr_lvl = cfg_wdata[LVL_W-1:0];

    // character codes: deliberately outside reset
    always_ff @(posedge clk) begin
        if (cfg_wr && cfg_addr == ADDR_STOP) codes.stop_code <= cfg_wdata;
        if (cfg_wr && cfg_addr == ADDR_GO)   codes.go_code   <= cfg_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_thr   <= HALT_RST;
            resume_thr <= RESUME_RST;
            trig_thr   <= TRIG_RST;
        end else if (cfg_wr) begin
            case (cfg_addr)
                ADDR_HALT:   halt_thr   <= wr_lvl;
                ADDR_RESUME: resume_thr <= wr_lvl;
                ADDR_TRIG:   trig_thr   <= wr_lvl;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/sfc_flow_fsm.sv
module sfc_flow_fsm
    import sfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] halt_thr,
    input  logic [LVL_W-1:0] resume_thr,
    input  logic [LVL_W-1:0] trig_thr,
    input  logic             ctl_taken,
    output flow_st_t         state,
    output logic             irq
);

    flow_st_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            FL_OPEN:      if (rx_level >= halt_thr)   nxt = FL_STOP_PEND;
            FL_STOP_PEND: if (ctl_taken)              nxt = FL_STOPPED;
            FL_STOPPED:   if (rx_level <= resume_thr) nxt = FL_GO_PEND;
            FL_GO_PEND:   if (ctl_taken)              nxt = FL_OPEN;
            default:                                  nxt = FL_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FL_OPEN;
            irq   <= 1'b0;
        end else begin
            state <= nxt;
            irq   <= (rx_level >= trig_thr);
        end
    end

endmodule

// File: rtl/sfc_rx_filter.sv
module sfc_rx_filter
    import sfc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ctl_codes_t codes,
    input  logic       rx_valid,
    input  byte_t      rx_data,
    output logic       rx_fifo_wr,
    output byte_t      rx_fifo_data,
    output logic       paused
);

    logic hit_stop, hit_go;

    assign hit_stop     = rx_valid && (rx_data == codes.stop_code);
    assign hit_go       = rx_valid && (rx_data == codes.go_code);
    assign rx_fifo_wr   = rx_valid && !is_ctl_code(rx_data, codes);
    assign rx_fifo_data = rx_data;

    always_ff @(posedge clk) begin
        if (rst)           paused <= 1'b0;
        else if (hit_stop) paused <= 1'b1;
        else if (hit_go)   paused <= 1'b0;
    end

endmodule

// File: rtl/sfc_tx_arb.sv
module sfc_tx_arb
    import sfc_pkg::*;
(
    input  flow_st_t   state,
    input  logic       paused,
    input  ctl_codes_t codes,
    input  logic       tx_valid,
    input  byte_t      tx_data,
    input  logic       ser_grant,
    output logic       ser_req,
    output byte_t      ser_byte,
    output logic       tx_pop,
    output logic       ctl_taken
);

    logic ctl_sel, data_ok;

    assign ctl_sel = ctl_pending(state);
    assign data_ok = tx_valid && !paused;

    always_comb begin
        if (ctl_sel)
            ser_byte = (state == FL_STOP_PEND) ? codes.stop_code : codes.go_code;
        else
            ser_byte = tx_data;
    end

    assign ser_req   = ctl_sel || data_ok;
    assign ctl_taken = ctl_sel && ser_grant;
    assign tx_pop    = !ctl_sel && data_ok && ser_grant;

endmodule

// File: rtl/sfc_flow_ctrl.sv
module sfc_flow_ctrl
    import sfc_pkg::*;
#(
    parameter int FIFO_DEPTH  = 64,
    parameter int HALT_INIT   = 60,
    parameter int RESUME_INIT = 32,
    parameter int TRIG_INIT   = 52,
    localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [2:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_fifo_wr,
    output logic [7:0]       rx_fifo_data,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             ser_req,
    output logic [7:0]       ser_byte,
    input  logic             ser_grant,
    output logic             irq
);

    ctl_codes_t       codes;
    logic [LVL_W-1:0] halt_thr, resume_thr, trig_thr;
    flow_st_t         flow_state;
    logic             paused;
    logic             ctl_taken;

    sfc_cfg_regs #(
        .LVL_W(LVL_W), .HALT_INIT(HALT_INIT),
        .RESUME_INIT(RESUME_INIT), .TRIG_INIT(TRIG_INIT)
    ) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .codes(codes), .halt_thr(halt_thr),
        .resume_thr(resume_thr), .trig_thr(trig_thr)
    );

    sfc_flow_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk(clk), .rst(rst), .rx_level(rx_level), .halt_thr(halt_thr),
        .resume_thr(resume_thr), .trig_thr(trig_thr), .ctl_taken(ctl_taken),
        .state(flow_state), .irq(irq)
    );

    sfc_rx_filter u_rx (
        .clk(clk), .rst(rst), .codes(codes), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_fifo_wr(rx_fifo_wr),
        .rx_fifo_data(rx_fifo_data), .paused(paused)
    );

    sfc_tx_arb u_tx (
        .state(flow_state), .paused(paused), .codes(codes),
        .tx_valid(tx_valid), .tx_data(tx_data), .ser_grant(ser_grant),
        .ser_req(ser_req), .ser_byte(ser_byte), .tx_pop(tx_pop),
        .ctl_taken(ctl_taken)
    );

endmodule

// File: rtl/sfc_flow_ctrl_chk.sv
module sfc_flow_ctrl_chk
    import sfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] rx_level,
    input logic [LVL_W-1:0] resume_thr,
    input logic [LVL_W-1:0] trig_thr,
    input ctl_codes_t       codes,
    input flow_st_t         flow_state,
    input logic             paused,
    input logic             rx_fifo_wr,
    input logic [7:0]       rx_fifo_data,
    input logic             tx_pop,
    input logic             ser_req,
    input logic             ser_grant,
    input logic             irq
);

    assert_pop_handshake_R9: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (ser_req && ser_grant));

    assert_ctl_not_stored_R5: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_wr |-> (rx_fifo_data != codes.stop_code && rx_fifo_data != codes.go_code));

    assert_paused_silent_R4: assert property (@(posedge clk) disable iff (rst)
        (paused && !ctl_pending(flow_state)) |-> !ser_req);

    assert_irq_high_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(rst)) |-> ($past(rx_level) >= $past(trig_thr)));

    assert_irq_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!irq && !$past(rst)) |-> ($past(rx_level) < $past(trig_thr)));

    assert_go_only_after_stop_R2: assert property (@(posedge clk) disable iff (rst)
        (flow_state == FL_GO_PEND && $past(flow_state) != FL_GO_PEND && !$past(rst))
        |-> ($past(flow_state) == FL_STOPPED && $past(rx_level) <= $past(resume_thr)));

    assert_reset_state_R8: assert property (@(posedge clk)
        rst |=> (flow_state == FL_OPEN && !paused && !irq));

endmodule

bind sfc_flow_ctrl sfc_flow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .rx_level(rx_level), .resume_thr(resume_thr),
    .trig_thr(trig_thr), .codes(codes), .flow_state(flow_state),
    .paused(paused), .rx_fifo_wr(rx_fifo_wr), .rx_fifo_data(rx_fifo_data),
    .tx_pop(tx_pop), .ser_req(ser_req), .ser_grant(ser_grant), .irq(irq)
);

// File: tb/sfc_flow_ctrl_test.sv
module sfc_flow_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [LW-1:0] rx_level = '0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_fifo_wr;
    logic [7:0]    rx_fifo_data;
    logic          tx_valid = 1'b0;
    logic [7:0]    tx_data = '0;
    logic          tx_pop;
    logic          ser_req;
    logic [7:0]    ser_byte;
    logic          ser_grant = 1'b0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0]    m_stop, m_go;
    logic [LW-1:0] m_halt, m_res, m_trig;
    int            m_st;
    bit            m_paused, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfc_flow_ctrl uut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_level(rx_level), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_fifo_wr(rx_fifo_wr), .rx_fifo_data(rx_fifo_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .ser_req(ser_req), .ser_byte(ser_byte), .ser_grant(ser_grant), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit f_ctl(int st);
        return (st == 1) || (st == 3);
    endfunction

    function automatic bit f_req(int st, bit p, bit tv);
        return f_ctl(st) || (!p && tv);
    endfunction

    function automatic logic [7:0] f_byte(int st, logic [7:0] td);
        if (st == 1) return m_stop;
        if (st == 3) return m_go;
        return td;
    endfunction

    function automatic int f_next(int st, int lvl, bit g);
        if (f_ctl(st) && g) return (st == 1) ? 2 : 0;
        if (st == 0 && lvl >= int'(m_halt)) return 1;
        if (st == 2 && lvl <= int'(m_res)) return 3;
        return st;
    endfunction

    task automatic step(input int lvl, input bit rv, input logic [7:0] rd,
                        input bit tv, input logic [7:0] td, input bit g,
                        input bit cw = 0, input logic [2:0] ca = 0,
                        input logic [7:0] cd = 0);
        bit e_req, e_pop, e_fwr;
        logic [7:0] e_byte;
        @(negedge clk);
        rx_level = LW'(lvl); rx_valid = rv; rx_data = rd;
        tx_valid = tv; tx_data = td; ser_grant = g;
        cfg_wr = cw; cfg_addr = ca; cfg_wdata = cd;
        #1;
        e_req  = f_req(m_st, m_paused, tv);
        e_byte = f_byte(m_st, td);
        e_pop  = !f_ctl(m_st) && e_req && g;
        e_fwr  = rv && rd != m_stop && rd != m_go;
        chk(ser_req == e_req, "R3 ser_req", int'(ser_req), int'(e_req));
        if (e_req) chk(ser_byte == e_byte, "R3 ser_byte", int'(ser_byte), int'(e_byte));
        chk(tx_pop == e_pop, "R9 tx_pop", int'(tx_pop), int'(e_pop));
        chk(rx_fifo_wr == e_fwr, "R5 rx_fifo_wr", int'(rx_fifo_wr), int'(e_fwr));
        if (e_fwr) chk(rx_fifo_data == rd, "R5 rx_fifo_data", int'(rx_fifo_data), int'(rd));
        chk(irq == m_irq, "R6 irq", int'(irq), int'(m_irq));
        @(posedge clk);
        m_st  = f_next(m_st, lvl, g);
        m_irq = (lvl >= int'(m_trig));
        if (rv && rd == m_stop) m_paused = 1;
        else if (rv && rd == m_go) m_paused = 0;
        if (cw) begin
            case (ca)
                3'd0: m_stop = cd;
                3'd1: m_go   = cd;
                3'd2: m_halt = cd[LW-1:0];
                3'd3: m_res  = cd[LW-1:0];
                3'd4: m_trig = cd[LW-1:0];
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int lvl);
        step(lvl, 0, 8'h00, 0, 8'h00, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; cfg_wr = 0; rx_valid = 0; tx_valid = 0; ser_grant = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_halt = 7'd60; m_res = 7'd32; m_trig = 7'd52;
        m_st = 0; m_paused = 0; m_irq = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int lvl;
        void'($urandom(32'h5fc0_1234));
        m_stop = 8'h00; m_go = 8'h00;
        do_reset();
        // R8: reset state
        #1;
        chk(irq == 0, "R8 irq after reset", int'(irq), 0);
        chk(ser_req == 0, "R8 ser_req after reset", int'(ser_req), 0);
        // R7: program codes
        step(0, 0, 0, 0, 0, 0, 1, 3'd0, 8'h0F);
        step(0, 0, 0, 0, 0, 0, 1, 3'd1, 8'h0D);

        // fill-and-drain scenario with default thresholds
        idle(52);
        idle(52);
        chk(irq == 1, "R6 irq at trigger 52", int'(irq), 1);
        step(59, 0, 0, 1, 8'h41, 1);           // data flows below halt
        step(60, 0, 0, 1, 8'h42, 0);
        #1;
        chk(ser_req && ser_byte == 8'h0F, "R1 stop char at 60", int'(ser_byte), 8'h0F);
        chk(tx_pop == 0, "R3 data held behind stop", int'(tx_pop), 0);
        step(61, 1, 8'h55, 1, 8'h42, 1);       // late byte accepted, stop sent
        step(62, 0, 0, 0, 0, 0);
        #1;
        chk(ser_req == 0, "R2 no second stop", int'(ser_req), 0);
        idle(40);
        idle(33);
        #1;
        chk(ser_req == 0, "R2 no go above resume", int'(ser_req), 0);
        idle(32);
        #1;
        chk(ser_req && ser_byte == 8'h0D, "R2 go char at 32", int'(ser_byte), 8'h0D);
        step(32, 0, 0, 0, 0, 1);

        // R4: far-end stop pauses data, control char still goes out
        step(10, 1, 8'h0F, 0, 0, 0);
        step(10, 0, 0, 1, 8'h77, 1);
        #1;
        chk(ser_req == 0, "R4 paused no data", int'(ser_req), 0);
        // R7: lower halt, R3: stop char sent while paused
        step(10, 0, 0, 1, 8'h77, 0, 1, 3'd2, 8'd8);
        step(10, 0, 0, 1, 8'h77, 0);
        #1;
        chk(ser_req && ser_byte == 8'h0F, "R3 ctl while paused", int'(ser_byte), 8'h0F);
        step(10, 0, 0, 1, 8'h77, 1);
        step(5, 1, 8'h0D, 1, 8'h77, 0);        // far-end go
        step(5, 0, 0, 1, 8'h78, 0);

        // R8: codes survive reset
        do_reset();
        step(0, 1, 8'h0F, 0, 0, 0);
        step(0, 1, 8'h0D, 0, 0, 0);
        #1;
        chk(rx_fifo_wr == 0, "R8 codes kept", int'(rx_fifo_wr), 0);

        // constrained random
        lvl = 0;
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic [7:0] rd;
            r = int'($urandom_range(0, 9));
            if (r < 2)      lvl = int'($urandom_range(0, 64));
            else if (r < 6) lvl = (lvl < 64) ? lvl + 1 : lvl;
            else            lvl = (lvl > 0) ? lvl - 1 : lvl;
            r = int'($urandom_range(0, 15));
            rd = (r == 0) ? 8'h0F : (r == 1) ? 8'h0D : 8'($urandom);
            if (i % 500 == 250)
                step(lvl, 0, 0, 1, 8'($urandom), 1, 1,
                     3'd3 + 3'($urandom_range(0, 1)), 8'($urandom_range(20, 50)));
            else
                step(lvl, $urandom_range(0, 2) == 0, rd, $urandom_range(0, 1) == 1,
                     8'($urandom), $urandom_range(0, 2) != 0);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule